// File: doc/BRIEF.md
# Serial Flash ID Reader

This controller fetches identification bytes from an SPI configuration flash. It has two request inputs. One asks for the silicon ID and the other asks for the capacity byte of the standard identification response. Each request is a level that is sampled on the rising system-clock edge. When the controller is idle and sees a sampled high level, it raises `busy`, runs one SPI transaction, and loads the byte it received into the output register for that command.

Each of the two ID outputs keeps its value until the next command of its own kind or until reset, so a requester can read either one at any time after the first fetch. Requests that arrive during a transaction are dropped. A request level that is still high when `busy` falls is sampled again and starts a new transaction. For a single read, the requester must lower its strobe before the transaction ends.

Top module: `flashid_reader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller resets to `sid_id` = 0, `cap_id` = 0, `busy` = 0, `spi_cs_n` = 1 and `spi_sclk` = 0.
- R2: Each request input is registered on the rising clock edge. If a high level is registered at edge k while the controller is idle, `busy` is high from edge k+1 onward.
- R3: The received ID byte is on its output in the first cycle that `busy` is low after the transaction.
- R4: `sid_id` changes only when a silicon ID transaction completes, and `cap_id` changes only when a capacity transaction completes. Neither output changes at any other time.
- R5: If a request is still high at the edge where `busy` falls, it is registered again and the same command runs once more.
- R6: A request that is registered while `busy` is high is ignored and starts no transaction.
- R7: If both requests are registered high in the same idle cycle, only the silicon ID transaction runs.
- R8: A silicon ID transaction sends opcode 0xAB, then 24 zero bits on `spi_mosi`, then reads 8 bits. The received byte goes to `sid_id`. The transaction is 40 serial-clock periods long.
- R9: A capacity transaction sends opcode 0x9F and reads 24 bits. The last 8 bits received go to `cap_id` and the first 16 are discarded. The transaction is 32 serial-clock periods long.
- R10: The SPI link uses mode 0 with data MSB first. `spi_sclk` toggles on every system clock cycle while `busy` is high, which makes it half the system clock rate. `spi_cs_n` is low for the whole time `busy` is high. When the controller is idle, `spi_cs_n` is high and `spi_sclk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_sid_req | input | 1 | Level request for a silicon ID read |
| rd_cap_req | input | 1 | Level request for a capacity ID read |
| busy | output | 1 | High while a transaction is in progress |
| sid_id | output | 8 | Last silicon ID received |
| cap_id | output | 8 | Last capacity ID received |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses a behavioural flash model. The model decodes the opcode it receives and answers with random ID bytes, and the bench runs randomly chosen commands against it. Since every response byte is random, a wrong bit position or a wrong kept byte shows up as a mismatch. The directed cases cover the following:
- a one-cycle strobe, which fixes when `busy` rises;
- both strobes in the same cycle, which shows the priority;
- a strobe pulsed during a transaction, which must be ignored;
- a strobe held past the fall of `busy`, which must start a second run;
- a stretch of idle cycles while the flash contents change, which must leave both ID outputs unchanged.

// File: rtl/flashid_pkg.sv
// Shared types and constants for the serial flash ID reader.
// Assumes a flash that accepts 8-bit opcodes, MSB first.
package flashid_pkg;
    typedef enum logic {CMD_SID = 1'b0, CMD_CAP = 1'b1} flash_cmd_e;
    localparam logic [7:0] OP_SID = 8'hAB;
    localparam logic [7:0] OP_CAP = 8'h9F;
    localparam int OP_BITS = 8;
endpackage

// File: rtl/flashid_req_arbiter.sv
// Registers the two request levels and decides which command starts.
// Assumes a requester holds each level for at least one full clock cycle.
// A registered level starts a command only while the engine is idle.
// The silicon ID request wins when both are registered together.
module flashid_req_arbiter
    import flashid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sid_req,
    input  logic       cap_req,
    input  logic       engine_busy,
    output logic       start,
    output flash_cmd_e start_cmd
);
    logic sid_q;
    logic cap_q;

    // Register both request levels on every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            sid_q <= sid_req;
            cap_q <= cap_req;
        end
    end

    // Start only when idle; the silicon ID request has priority.
    always_comb begin
        start     = !engine_busy && (sid_q || cap_q);
        start_cmd = sid_q ? CMD_SID : CMD_CAP;
    end
endmodule

// File: rtl/flashid_spi_engine.sv
// Runs one mode-0 SPI transaction. The serial clock runs at half the system clock.
// Sends the opcode, then zero bits, and keeps the last ID_W bits read on MISO.
// Assumes MISO changes only after a falling serial clock edge.
module flashid_spi_engine
    import flashid_pkg::*;
#(
    parameter int ID_W       = 8,
    parameter int SID_DUMMY  = 3,
    parameter int CAP_SKIP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  flash_cmd_e       start_cmd,
    input  logic             miso,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output flash_cmd_e       done_cmd,
    output logic [ID_W-1:0]  rx_byte
);
    localparam int SID_BITS = OP_BITS + 8 * SID_DUMMY + ID_W;
    localparam int CAP_BITS = OP_BITS + 8 * CAP_SKIP + ID_W;
    localparam int MAX_BITS = (SID_BITS > CAP_BITS) ? SID_BITS : CAP_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam logic [CNT_W-1:0] SID_LAST = CNT_W'(SID_BITS - 1);
    localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CAP_BITS - 1);

    logic               busy_q;
    logic               cs_q;
    logic               sclk_q;
    logic [OP_BITS-1:0] tx_q;
    logic [ID_W-1:0]    rx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   last_q;
    flash_cmd_e         cmd_q;

    // The last bit finishes on the falling serial clock edge of the last period.
    always_comb done = busy_q && sclk_q && (cnt_q == last_q);

    // Sequence the chip select, serial clock, shift registers and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            last_q <= '0;
            cmd_q  <= CMD_SID;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cs_q   <= 1'b0;
                cnt_q  <= '0;
                cmd_q  <= start_cmd;
                tx_q   <= (start_cmd == CMD_SID) ? OP_SID : OP_CAP;
                last_q <= (start_cmd == CMD_SID) ? SID_LAST : CAP_LAST;
            end
        end else if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[ID_W-2:0], miso};
        end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[OP_BITS-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
            if (done) begin
                busy_q <= 1'b0;
                cs_q   <= 1'b1;
                tx_q   <= '0;
            end
        end
    end

    assign busy     = busy_q;
    assign cs_n     = cs_q;
    assign sclk     = sclk_q;
    assign mosi     = tx_q[OP_BITS-1];
    assign done_cmd = cmd_q;
    assign rx_byte  = rx_q;
endmodule

// File: rtl/flashid_result_regs.sv
// Holds one sticky result register per ID command.
// A register loads only when a transaction of its own command completes.
// Assumes done is a single-cycle pulse.
module flashid_result_regs
    import flashid_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done,
    input  flash_cmd_e      done_cmd,
    input  logic [ID_W-1:0] rx_byte,
    output logic [ID_W-1:0] sid_val,
    output logic [ID_W-1:0] cap_val
);
    // Load the register that matches the completed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_val <= '0;
            cap_val <= '0;
        end else if (done) begin
            if (done_cmd == CMD_SID) sid_val <= rx_byte;
            else                     cap_val <= rx_byte;
        end
    end
endmodule

// File: rtl/flashid_reader.sv
// Top level of the serial flash ID reader.
// Connects the request arbiter, the SPI engine and the sticky result registers.
// Assumes a synchronous active-low reset and one flash device on the link.
module flashid_reader
    import flashid_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int SID_DUMMY = 3,
    parameter int CAP_SKIP  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_sid_req,
    input  logic            rd_cap_req,
    output logic            busy,
    output logic [ID_W-1:0] sid_id,
    output logic [ID_W-1:0] cap_id,
    output logic            spi_cs_n,
    output logic            spi_sclk,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    logic            start;
    flash_cmd_e      start_cmd;
    logic            done;
    flash_cmd_e      done_cmd;
    logic [ID_W-1:0] rx_byte;

    flashid_req_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .sid_req(rd_sid_req), .cap_req(rd_cap_req),
        .engine_busy(busy), .start(start), .start_cmd(start_cmd)
    );

    flashid_spi_engine #(.ID_W(ID_W), .SID_DUMMY(SID_DUMMY), .CAP_SKIP(CAP_SKIP)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(start_cmd),
        .miso(spi_miso), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
        .mosi(spi_mosi), .done(done), .done_cmd(done_cmd), .rx_byte(rx_byte)
    );

    flashid_result_regs #(.ID_W(ID_W)) u_res (
        .clk(clk), .rst_n(rst_n), .done(done), .done_cmd(done_cmd),
        .rx_byte(rx_byte), .sid_val(sid_id), .cap_val(cap_id)
    );
endmodule

// File: rtl/flashid_reader_chk.sv
// Property checker for the serial flash ID reader. It is attached with bind.
module flashid_reader_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_sid_req,
    input logic            rd_cap_req,
    input logic            busy,
    input logic [ID_W-1:0] sid_id,
    input logic [ID_W-1:0] cap_id,
    input logic            spi_cs_n,
    input logic            spi_sclk
);
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(rd_sid_req, 2) || $past(rd_cap_req, 2)));

    // R4
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(sid_id) && $stable(cap_id)));

    // R10
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sclk));

    // R10
    cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !spi_cs_n);

    // R10
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (spi_sclk != $past(spi_sclk)));
endmodule

bind flashid_reader flashid_reader_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sid_req(rd_sid_req), .rd_cap_req(rd_cap_req),
    .busy(busy), .sid_id(sid_id), .cap_id(cap_id),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk)
);

// File: tb/flashid_reader_bench.sv
module flashid_reader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_sid_req = 1'b0;
    logic       rd_cap_req = 1'b0;
    logic       busy;
    logic [7:0] sid_id;
    logic [7:0] cap_id;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int fails = 0;

    // Flash contents, changed by the bench.
    logic [7:0] fl_sid = 8'h00;
    logic [7:0] fl_mfr = 8'h00;
    logic [7:0] fl_typ = 8'h00;
    logic [7:0] fl_cap = 8'h00;

    // Flash model state.
    logic [7:0] fl_op = 8'h00;
    int fl_bits = 0;
    int fl_dummy_hi = 0;
    logic [7:0] last_op = 8'h00;
    int last_bits = 0;
    int last_dummy_hi = 0;
    int txn_count = 0;
    int pin_errs = 0;

    logic [7:0] exp_sid = 8'h00;
    logic [7:0] exp_cap = 8'h00;

    always #2 clk = ~clk;

    flashid_reader u_flashid_reader (
        .clk(clk), .rst_n(rst_n), .rd_sid_req(rd_sid_req), .rd_cap_req(rd_cap_req),
        .busy(busy), .sid_id(sid_id), .cap_id(cap_id), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Expected response bit at a given bit index of a transaction.
    function automatic logic resp_bit(input logic [7:0] op, input int idx);
        logic [23:0] jedec;
        jedec = {fl_mfr, fl_typ, fl_cap};
        if (op == 8'hAB && idx >= 32 && idx < 40) return fl_sid[39 - idx];
        if (op == 8'h9F && idx >= 8 && idx < 32)  return jedec[31 - idx];
        return 1'b0;
    endfunction

    // Bits per transaction from the requirements.
    function automatic int exp_bits(input logic [7:0] op);
        return (op == 8'hAB) ? 40 : 32;
    endfunction

    // Flash side: sample MOSI on the rising serial clock; record a transaction on deselect.
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            last_op       <= fl_op;
            last_bits     <= fl_bits;
            last_dummy_hi <= fl_dummy_hi;
            txn_count     <= txn_count + 1;
            fl_bits       <= 0;
            fl_dummy_hi   <= 0;
        end else begin
            if (fl_bits < 8) fl_op <= {fl_op[6:0], spi_mosi};
            else if (spi_mosi) fl_dummy_hi <= fl_dummy_hi + 1;
            fl_bits <= fl_bits + 1;
        end
    end

    // Flash side: present the next bit after each falling serial clock.
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) spi_miso <= resp_bit(fl_op, fl_bits);
    end

    // Pin monitor for R10 between system edges.
    always @(negedge clk) begin
        if (rst_n && busy && spi_cs_n) pin_errs <= pin_errs + 1;
        if (rst_n && spi_cs_n && spi_sclk) pin_errs <= pin_errs + 1;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk(1'b0, "watchdog busy stuck", 1, 0);
    endtask

    task automatic randomize_flash();
        fl_sid = 8'($urandom);
        fl_mfr = 8'($urandom);
        fl_typ = 8'($urandom);
        fl_cap = 8'($urandom);
    endtask

    // Pulse one or both strobes for one cycle, check busy timing, wait for the end.
    task automatic run_one(input logic do_sid, input logic do_cap, input string tag);
        rd_sid_req = do_sid;
        rd_cap_req = do_cap;
        @(negedge clk);
        rd_sid_req = 1'b0;
        rd_cap_req = 1'b0;
        chk(busy == 1'b0, {tag, " R2 busy still low one cycle after registration"}, busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, {tag, " R2 busy high"}, busy, 1);
        wait_idle();
        if (do_sid) exp_sid = fl_sid;
        else        exp_cap = fl_cap;
    endtask

    task automatic check_ids(input string tag);
        chk(sid_id == exp_sid, {tag, " R3 R8 sid_id"}, sid_id, exp_sid);
        chk(cap_id == exp_cap, {tag, " R3 R9 cap_id"}, cap_id, exp_cap);
    endtask

    task automatic check_frame(input logic [7:0] op, input string tag);
        @(negedge clk);
        chk(last_op == op, {tag, " opcode"}, last_op, op);
        chk(last_bits == exp_bits(op), {tag, " bit count"}, last_bits, exp_bits(op));
        chk(last_dummy_hi == 0, {tag, " R8 trailing MOSI zero"}, last_dummy_hi, 0);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20250607));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sid_id == 8'h00 && cap_id == 8'h00, "R1 ids zero", {sid_id, cap_id}, 0);
        chk(busy == 1'b0, "R1 busy low", busy, 0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 cs high sclk low", {spi_cs_n, spi_sclk}, 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 directed silicon ID read
        fl_sid = 8'hA5; fl_mfr = 8'h20; fl_typ = 8'h5A; fl_cap = 8'h17;
        run_one(1'b1, 1'b0, "sid");
        check_ids("sid");
        check_frame(8'hAB, "R8 sid");

        // R9 directed capacity read
        run_one(1'b0, 1'b1, "cap");
        check_ids("cap");
        check_frame(8'h9F, "R9 cap");

        // R7 both strobes together: only silicon ID runs
        randomize_flash();
        base = txn_count;
        run_one(1'b1, 1'b1, "both");
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R7 no second run", busy, 0);
        chk(txn_count == base + 1, "R7 one transaction", txn_count - base, 1);
        chk(last_op == 8'hAB, "R7 silicon ID wins", last_op, 8'hAB);
        check_ids("R7");

        // R6 requests during busy are ignored
        randomize_flash();
        base = txn_count;
        rd_sid_req = 1'b1;
        @(negedge clk);
        rd_sid_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_cap_req = 1'b1;
        @(negedge clk);
        rd_cap_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_sid_req = 1'b1;
        @(negedge clk);
        rd_sid_req = 1'b0;
        wait_idle();
        exp_sid = fl_sid;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R6 stays idle", busy, 0);
        chk(txn_count == base + 1, "R6 one transaction", txn_count - base, 1);
        check_ids("R6");

        // R5 strobe held through the fall of busy reruns the command
        randomize_flash();
        base = txn_count;
        rd_cap_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wait_idle();
        rd_cap_req = 1'b0;
        exp_cap = fl_cap;
        @(negedge clk);
        chk(busy == 1'b1, "R5 rerun starts", busy, 1);
        fl_cap = 8'($urandom);
        wait_idle();
        exp_cap = fl_cap;
        repeat (6) @(negedge clk);
        chk(txn_count == base + 2, "R5 two transactions", txn_count - base, 2);
        check_ids("R5");

        // R4 outputs hold while idle even when the flash changes
        randomize_flash();
        repeat (30) @(negedge clk);
        check_ids("R4 idle hold");

        // Random commands
        for (int i = 0; i < 40; i++) begin
            logic [1:0] pick;
            randomize_flash();
            pick = 2'($urandom_range(0, 2));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            run_one(pick != 2'd1, pick != 2'd0, "rand");
            check_ids("rand R4");
            check_frame((pick != 2'd1) ? 8'hAB : 8'h9F, "rand R8 R9");
        end

        chk(pin_errs == 0, "R10 cs and sclk pin rules", pin_errs, 0);
        summary();
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 1, 0);
        summary();
    end
endmodule